// File: doc/BRIEF.md
# Network-Side Link Activation Controller

This block runs the network end of the activation handshake on a four-wire 2B+D subscriber bus. It watches software requests to bring the link up or take it down. It also watches an indication from the receiver that the far end is sending something other than an idle line, a frame-alignment indication and a slow timing tick. From these it decides which line signal the transmitter must send: an idle line, the sync frame, or the normal data frame. It also sets the activation bit carried in each outgoing frame.

The controller has four states and reports its state as a two-bit code. It also gates the serial-to-line data path. Data from the system serial bus reaches the line only once the link is fully active; in every other state the gated data is forced to zero. Deactivation waits in an intermediate state. That state ends when a millisecond-tick timeout expires or when the far end falls silent.

Top module: `nt_act_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the state becomes deactivated: `state_code`=00, `line_sig`=00 (idle), `a_bit`=0.
- R2: In the deactivated state, an activation request sampled at a frame strobe moves the block to pending-activation. This happens on the second clock edge after the strobe edge. Pending-activation reports `state_code`=01, `line_sig`=01 (sync frame) and `a_bit`=0.
- R3: In the deactivated state, `bus_active` high at a clock edge moves the block to pending-activation at that edge, with no request needed.
- R4: In pending-activation, `frame_sync` high at an edge moves the block to activated. Activated reports `state_code`=11, `line_sig`=10 (normal frame) and `a_bit`=1.
- R5: In activated, `frame_sync` low at an edge returns the block to pending-activation, and `a_bit` returns to 0.
- R6: A deactivation request sampled at a frame strobe moves the block from pending-activation or activated to pending-deactivation, on the second edge after the strobe. Pending-deactivation reports `state_code`=10 and `line_sig`=00.
- R7: In pending-deactivation with `bus_active` high, the block returns to deactivated at the edge of the TIMEOUT_TICKS-th `ms_tick` (32 by default). After one tick fewer it is still pending-deactivation.
- R8: In pending-deactivation, `bus_active` low at an edge moves the block to deactivated.
- R9: `line_data_out` equals `ser_data_in` while `state_code`=11, and is zero in every other state.
- R10: `act_req` and `deact_req` have no effect at edges where `frame_strobe` is low.
- R11: When both requests are high at the same frame strobe, the deactivation request alone takes effect. In deactivated the block stays put; in activated it goes to pending-deactivation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_strobe | input | 1 | Once-per-frame pulse at which requests are sampled |
| act_req | input | 1 | Software activation request |
| deact_req | input | 1 | Software deactivation request |
| bus_active | input | 1 | Far end is sending a non-idle signal |
| frame_sync | input | 1 | Receiver holds frame alignment |
| ms_tick | input | 1 | One-cycle enable, nominally once per millisecond |
| ser_data_in | input | DATA_W | Data from the system serial bus toward the line |
| line_data_out | output | DATA_W | Gated data toward the line transmitter |
| line_sig | output | 2 | Line signal to send: 00 idle, 01 sync frame, 10 normal frame |
| a_bit | output | 1 | Activation bit for outgoing frames |
| state_code | output | 2 | 00 deactivated, 01 pending-activation, 11 activated, 10 pending-deactivation |

## Verification
Two collisions can land in the same cycle.

The first is a frame strobe that carries both requests. The bench raises both bits at one strobe, once in the deactivated state and once in the activated state. It expects only the deactivation outcome two edges later. A copy of the design that lets activation win would move to the sync frame instead.

The second collision is in pending-deactivation: the final timeout tick arrives in the same cycle that bus activity drops. Both paths lead to deactivated, so the state code must read 00 after that one edge. The bench also places a final tick together with continuing activity, which must produce deactivated for exactly one cycle before activity restarts the handshake.

// File: rtl/nt_act_pkg.sv
package nt_act_pkg;

    typedef enum logic [1:0] {
        ST_DEACT      = 2'b00,
        ST_PEND_ACT   = 2'b01,
        ST_PEND_DEACT = 2'b10,
        ST_ACT        = 2'b11
    } act_state_e;

    typedef enum logic [1:0] {
        SIG_IDLE         = 2'b00,
        SIG_SYNC_FRAME   = 2'b01,
        SIG_NORMAL_FRAME = 2'b10
    } line_sig_e;

    typedef struct packed {
        logic act;
        logic deact;
    } req_evt_t;

    typedef struct packed {
        line_sig_e sig;
        logic      a_bit;
        logic      pass_data;
    } line_ctl_t;

    function automatic line_ctl_t decode_state(act_state_e s);
        line_ctl_t c;
        c.sig       = SIG_IDLE;
        c.a_bit     = 1'b0;
        c.pass_data = 1'b0;
        case (s)
            ST_PEND_ACT: c.sig = SIG_SYNC_FRAME;
            ST_ACT: begin
                c.sig       = SIG_NORMAL_FRAME;
                c.a_bit     = 1'b1;
                c.pass_data = 1'b1;
            end
            default: c.sig = SIG_IDLE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/nt_act_req_sampler.sv
module nt_act_req_sampler
    import nt_act_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     frame_strobe,
    input  logic     act_req,
    input  logic     deact_req,
    output req_evt_t evt
);

    req_evt_t evt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            evt_q <= '0;
        end else if (frame_strobe) begin
            evt_q.deact <= deact_req;
            evt_q.act   <= act_req & ~deact_req;
        end else begin
            evt_q <= '0;
        end
    end

    assign evt = evt_q;

    a_r10_no_evt_without_strobe: assert property (@(posedge clk) disable iff (rst)
        !frame_strobe |=> (evt == '0));

    a_r11_deact_wins: assert property (@(posedge clk) disable iff (rst)
        (frame_strobe && act_req && deact_req) |=> (evt.deact && !evt.act));

endmodule

// File: rtl/nt_act_timer.sv
module nt_act_timer #(
    parameter int TIMEOUT_TICKS = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    output logic expire
);

    localparam int CW = $clog2(TIMEOUT_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_TICKS - 1);

    logic [CW-1:0] count;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            count <= '0;
        end else if (tick && count != LAST) begin
            count <= count + 1'b1;
        end
    end

    assign expire = run && tick && (count == LAST);

    a_r7_idle_clears: assert property (@(posedge clk) disable iff (rst)
        !run |=> (count == '0));

    a_r7_no_early_expire: assert property (@(posedge clk) disable iff (rst)
        (run && !tick) |-> !expire);

endmodule

// File: rtl/nt_act_fsm.sv
module nt_act_fsm
    import nt_act_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  req_evt_t   evt,
    input  logic       bus_active,
    input  logic       frame_sync,
    input  logic       timer_expire,
    output act_state_e state
);

    act_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_DEACT: begin
                if (!evt.deact && (evt.act || bus_active)) state_d = ST_PEND_ACT;
            end
            ST_PEND_ACT: begin
                if (evt.deact)       state_d = ST_PEND_DEACT;
                else if (frame_sync) state_d = ST_ACT;
            end
            ST_ACT: begin
                if (evt.deact)        state_d = ST_PEND_DEACT;
                else if (!frame_sync) state_d = ST_PEND_ACT;
            end
            ST_PEND_DEACT: begin
                if (timer_expire || !bus_active) state_d = ST_DEACT;
            end
            default: state_d = ST_DEACT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_DEACT;
        else     state_q <= state_d;
    end

    assign state = state_q;

    a_r1_reset_deact: assert property (@(posedge clk)
        rst |=> (state_q == ST_DEACT));

    a_r4_sync_activates: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PEND_ACT && !evt.deact && frame_sync) |=> (state_q == ST_ACT));

    a_r5_sync_loss: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ACT && !evt.deact && !frame_sync) |=> (state_q == ST_PEND_ACT));

    a_r6_deact_request: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_PEND_ACT || state_q == ST_ACT) && evt.deact) |=> (state_q == ST_PEND_DEACT));

    a_r8_silence_ends: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PEND_DEACT && !bus_active) |=> (state_q == ST_DEACT));

endmodule

// File: rtl/nt_act_ctrl.sv
module nt_act_ctrl
    import nt_act_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int TIMEOUT_TICKS = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_strobe,
    input  logic              act_req,
    input  logic              deact_req,
    input  logic              bus_active,
    input  logic              frame_sync,
    input  logic              ms_tick,
    input  logic [DATA_W-1:0] ser_data_in,
    output logic [DATA_W-1:0] line_data_out,
    output logic [1:0]        line_sig,
    output logic              a_bit,
    output logic [1:0]        state_code
);

    req_evt_t   evt;
    act_state_e state;
    logic       expire;
    line_ctl_t  ctl;

    nt_act_req_sampler u_sampler (
        .clk          (clk),
        .rst          (rst),
        .frame_strobe (frame_strobe),
        .act_req      (act_req),
        .deact_req    (deact_req),
        .evt          (evt)
    );

    nt_act_timer #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .run    (state == ST_PEND_DEACT),
        .tick   (ms_tick),
        .expire (expire)
    );

    nt_act_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .evt          (evt),
        .bus_active   (bus_active),
        .frame_sync   (frame_sync),
        .timer_expire (expire),
        .state        (state)
    );

    assign ctl           = decode_state(state);
    assign line_sig      = ctl.sig;
    assign a_bit         = ctl.a_bit;
    assign state_code    = state;
    assign line_data_out = ctl.pass_data ? ser_data_in : '0;

    a_r9_gate_closed: assert property (@(posedge clk) disable iff (rst)
        (state_code != 2'b11) |-> (line_data_out == '0));

    a_r4_abit_follows_frame: assert property (@(posedge clk) disable iff (rst)
        a_bit |-> (line_sig == 2'b10));

endmodule

// File: tb/tb_nt_act_ctrl.sv
module tb_nt_act_ctrl;

    localparam int DATA_W = 8;

    typedef struct {
        logic [1:0]        code;
        logic [DATA_W-1:0] data;
        string             req;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              frame_strobe = 1'b0;
    logic              act_req = 1'b0;
    logic              deact_req = 1'b0;
    logic              bus_active = 1'b0;
    logic              frame_sync = 1'b0;
    logic              ms_tick = 1'b0;
    logic [DATA_W-1:0] ser_data_in = '0;
    logic [DATA_W-1:0] line_data_out;
    logic [1:0]        line_sig;
    logic              a_bit;
    logic [1:0]        state_code;

    int   checks = 0;
    int   fails  = 0;
    bit   done   = 0;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    nt_act_ctrl #(.DATA_W(DATA_W), .TIMEOUT_TICKS(32)) dut (
        .clk(clk), .rst(rst), .frame_strobe(frame_strobe), .act_req(act_req),
        .deact_req(deact_req), .bus_active(bus_active), .frame_sync(frame_sync),
        .ms_tick(ms_tick), .ser_data_in(ser_data_in), .line_data_out(line_data_out),
        .line_sig(line_sig), .a_bit(a_bit), .state_code(state_code)
    );

    // drive one cycle of inputs and queue the state expected after the next edge
    task automatic step(input logic r, input logic strb, input logic ar, input logic dr,
                        input logic bus, input logic sync, input logic tick,
                        input logic [DATA_W-1:0] d, input logic [1:0] code, input string req);
        exp_t e;
        @(negedge clk);
        rst = r; frame_strobe = strb; act_req = ar; deact_req = dr;
        bus_active = bus; frame_sync = sync; ms_tick = tick; ser_data_in = d;
        e.code = code;
        e.data = (code == 2'b11) ? d : '0;
        e.req  = req;
        exp_q.push_back(e);
    endtask

    // monitor: compares outputs a quarter period after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1.25;
            if (exp_q.size() > 0) begin
                exp_t e;
                logic [1:0] es;
                logic       ea;
                e  = exp_q.pop_front();
                es = (e.code == 2'b01) ? 2'b01 : (e.code == 2'b11) ? 2'b10 : 2'b00;
                ea = (e.code == 2'b11);
                checks++;
                if (state_code !== e.code || line_sig !== es || a_bit !== ea || line_data_out !== e.data) begin
                    fails++;
                    $display("FAIL %s: code=%b sig=%b a=%b data=%h expected code=%b sig=%b a=%b data=%h",
                             e.req, state_code, line_sig, a_bit, line_data_out, e.code, es, ea, e.data);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        step(1, 0, 0, 0, 0, 0, 0, 8'h00, 2'b00, "R1");
        step(1, 0, 0, 0, 0, 0, 0, 8'h00, 2'b00, "R1");
        // R10: requests without a strobe are ignored
        step(0, 0, 1, 0, 0, 0, 0, 8'h11, 2'b00, "R10");
        step(0, 0, 1, 0, 0, 0, 0, 8'h12, 2'b00, "R10");
        step(0, 0, 0, 0, 0, 0, 0, 8'h13, 2'b00, "R10");
        // R2: strobed activation request
        step(0, 1, 1, 0, 0, 0, 0, 8'h00, 2'b00, "R2");
        step(0, 0, 0, 0, 0, 0, 0, 8'hA5, 2'b01, "R2");
        step(0, 0, 0, 0, 0, 0, 0, 8'h5A, 2'b01, "R9");
        // R4: sync brings activation, R9 data passes
        step(0, 0, 0, 0, 1, 1, 0, 8'h3C, 2'b11, "R4");
        step(0, 0, 0, 0, 1, 1, 0, 8'hC3, 2'b11, "R9");
        step(0, 0, 0, 0, 1, 1, 0, 8'hFF, 2'b11, "R9");
        // R10: deactivation request without strobe is ignored
        step(0, 0, 0, 1, 1, 1, 0, 8'h01, 2'b11, "R10");
        step(0, 0, 0, 0, 1, 1, 0, 8'h02, 2'b11, "R10");
        // R5: sync loss and recovery
        step(0, 0, 0, 0, 1, 0, 0, 8'h77, 2'b01, "R5");
        step(0, 0, 0, 0, 1, 1, 0, 8'h78, 2'b11, "R4");
        // R6: deactivation request from activated
        step(0, 1, 0, 1, 1, 1, 0, 8'h44, 2'b11, "R6");
        step(0, 0, 0, 0, 1, 1, 0, 8'h45, 2'b10, "R6");
        // R7: timeout of 32 ticks with bus still active
        for (int i = 0; i < 31; i++) begin
            step(0, 0, 0, 0, 1, 0, 1, 8'h66, 2'b10, "R7");
            step(0, 0, 0, 0, 1, 0, 0, 8'h66, 2'b10, "R7");
        end
        step(0, 0, 0, 0, 1, 0, 1, 8'h66, 2'b00, "R7");
        // R3: bus activity alone restarts activation
        step(0, 0, 0, 0, 1, 0, 0, 8'h66, 2'b01, "R3");
        step(0, 0, 0, 0, 1, 0, 0, 8'h66, 2'b01, "R3");
        // R6: deactivation request from pending-activation
        step(0, 1, 0, 1, 1, 0, 0, 8'h00, 2'b01, "R6");
        step(0, 0, 0, 0, 1, 0, 0, 8'h00, 2'b10, "R6");
        // R8: silence ends pending-deactivation
        step(0, 0, 0, 0, 0, 0, 0, 8'h00, 2'b00, "R8");
        step(0, 0, 0, 0, 0, 0, 0, 8'h00, 2'b00, "R8");
        // R11: both requests in deactivated
        step(0, 1, 1, 1, 0, 0, 0, 8'h00, 2'b00, "R11");
        step(0, 0, 0, 0, 0, 0, 0, 8'h00, 2'b00, "R11");
        step(0, 0, 0, 0, 0, 0, 0, 8'h00, 2'b00, "R11");
        // R11: both requests in activated
        step(0, 1, 1, 0, 0, 0, 0, 8'h00, 2'b00, "R2");
        step(0, 0, 0, 0, 1, 0, 0, 8'h00, 2'b01, "R2");
        step(0, 0, 0, 0, 1, 1, 0, 8'h9E, 2'b11, "R4");
        step(0, 1, 1, 1, 1, 1, 0, 8'h9F, 2'b11, "R11");
        step(0, 0, 0, 0, 1, 1, 0, 8'hA0, 2'b10, "R11");
        // same cycle: final tick and silence together
        for (int i = 0; i < 31; i++)
            step(0, 0, 0, 0, 1, 0, 1, 8'h00, 2'b10, "R7");
        step(0, 0, 0, 0, 0, 0, 1, 8'h00, 2'b00, "R8");
        step(0, 0, 0, 0, 0, 0, 0, 8'h00, 2'b00, "R8");
        // R1: reset from activated
        step(0, 0, 0, 0, 1, 0, 0, 8'h00, 2'b01, "R3");
        step(0, 0, 0, 0, 1, 1, 0, 8'h21, 2'b11, "R4");
        step(1, 0, 0, 0, 1, 1, 0, 8'h22, 2'b00, "R1");
        step(0, 0, 0, 0, 0, 0, 0, 8'h23, 2'b00, "R1");
        repeat (3) @(posedge clk);
        #2;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule